// File: doc/BRIEF.md
# Round-Robin Slot Scheduler with Idle-Slot Power-Down

This block decides, once per fixed scheduling interval, which agent of a real-time SDRAM controller gets the next service slot. Requesters hold a valid line high; at each slot boundary the scheduler gives a one-cycle grant to the first valid requester found at or after a rotating pointer. That way every busy requester is served once in every round of `NUM_REQ` slots. A pending refresh takes precedence and consumes the slot without moving the pointer.

When a slot boundary finds no refresh and no valid requester, the slot is idle. The scheduler then sends a single-cycle power-off order to the command generator. The order carries the residency time that fits between the entry and exit transitions inside one interval. The whole power-off episode, which is entry, residency and wake-up, closes within that idle slot, so the next boundary comes at exactly the same cycle as it would without power-down. Requesters therefore see unchanged grant timing.

The command generator and its timing checks sit outside this block. Every order the scheduler issues (grant, refresh, power-off) stays outstanding until the generator pulses `cmdDone`. No new decision is made before that pulse, so a longer service cycle or a refresh stretches the slot.

Top module: `slot_pd_sched`

## Requirements
- R1: During reset and directly after it, grant, refGo and offGo are low, memDown is low, and the pointer starts at requester 0, so the first decision with all requesters valid grants requester 0 (grant bit 0).
- R2: Decisions are spaced by at least SCHED_INT (default 26) cycles. When each order completes in time, consecutive strobes are exactly SCHED_INT cycles apart.
- R3: A grant is a one-cycle one-hot pulse on bit i for the first requester i, searching upward with wrap from the pointer, whose reqValid[i] was high at the decision edge. The pointer then moves to i+1, modulo NUM_REQ.
- R4: A decision with no refresh and no valid requester issues a one-cycle offGo, and offTime equals SCHED_INT - T_ENTER - T_EXIT (default 16).
- R5: Idle slots and refresh slots leave the pointer unchanged.
- R6: refReq high at a decision edge issues a one-cycle refGo and no grant, whatever the requests are.
- R7: After any strobe, no further decision is taken until cmdDone has been seen, so a 37-cycle write or a 44-cycle refresh stretches the slot to that length.
- R8: memDown goes high the cycle offGo is issued and falls after the edge at which cmdDone is sampled.
- R9: A request raised partway through an idle slot is granted exactly SCHED_INT cycles after the offGo, the same cycle as with no power-down.
- R10: At most one of grant, refGo and offGo is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | NUM_REQ | Per-requester request pending |
| refReq | input | 1 | Refresh pending; takes the next slot |
| cmdDone | input | 1 | One-cycle pulse when the outstanding order completes |
| grant | output | NUM_REQ | One-hot, one-cycle slot grant |
| refGo | output | 1 | One-cycle refresh order |
| offGo | output | 1 | One-cycle power-off order |
| offTime | output | TW | Residency cycles carried with offGo |
| memDown | output | 1 | Power-off episode in progress |

## Verification
The bench attacks slot timing around idle slots. A request raised in the middle of a power-off episode must be granted on the unchanged boundary; a design that waited for an extra wake-up period or re-armed the interval late would grant it one or more cycles off. Slots after an idle slot and after a refresh check that the pointer has not moved, since a design that advanced it would skip a requester. Stretched slots, a 37-cycle write and a 44-cycle refresh, expose a scheduler that decides on its timer alone and ignores the completion pulse. Every cycle is compared against a behavioural model, so a wrong winner, a dropped offGo or a memDown that falls early is reported.

// File: rtl/slot_pd_pkg.sv
package slot_pd_pkg;
  typedef struct packed {
    logic decide;
    logic takeRef;
    logic takeReq;
    logic takeOff;
  } slotStrobeT;
endpackage

// File: rtl/slot_pd_ctrl.sv
module slot_pd_ctrl
  import slot_pd_pkg::*;
#(
  parameter int SCHED_INT = 26
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  input  logic       refReq,
  input  logic       cmdDone,
  output slotStrobeT strb
);
  localparam int CW = $clog2(SCHED_INT + 1);

  logic [CW-1:0] slotCnt;
  logic          busy;
  logic          decide;

  // A decision needs the interval elapsed and the previous order finished.
  assign decide       = (slotCnt == '0) && (!busy || cmdDone);
  assign strb.decide  = decide;
  assign strb.takeRef = decide && refReq;
  assign strb.takeReq = decide && !refReq && anyReq;
  assign strb.takeOff = decide && !refReq && !anyReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt <= '0;
      busy    <= 1'b0;
    end else if (decide) begin
      slotCnt <= CW'(SCHED_INT - 1);
      busy    <= 1'b1;
    end else begin
      if (slotCnt != '0) slotCnt <= slotCnt - 1'b1;
      if (cmdDone) busy <= 1'b0;
    end
  end

  // R7: while an order is outstanding and no completion arrives, nothing is decided
  a_r7_wait_done: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.decide) && !cmdDone) |=> !strb.decide);
endmodule

// File: rtl/slot_pd_dp.sv
module slot_pd_dp
  import slot_pd_pkg::*;
#(
  parameter int NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqValid,
  input  logic               refReq,
  input  logic               cmdDone,
  input  slotStrobeT         strb,
  output logic               anyReq,
  output logic [NUM_REQ-1:0] grant,
  output logic               refGo,
  output logic               offGo,
  output logic               memDown
);
  localparam int IW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic [IW-1:0]      ptr;
  logic [IW-1:0]      pickIdx;
  logic [IW-1:0]      ptrNext;
  logic [NUM_REQ-1:0] grantNext;

  assign anyReq = |reqValid;

  // Search upward from the pointer with wrap; the first hit wins.
  always_comb begin
    logic found;
    found   = 1'b0;
    pickIdx = ptr;
    for (int k = 0; k < NUM_REQ; k++) begin
      int idx;
      idx = (int'(ptr) + k) % NUM_REQ;
      if (!found && reqValid[idx]) begin
        found   = 1'b1;
        pickIdx = IW'(idx);
      end
    end
  end

  assign ptrNext = (int'(pickIdx) == NUM_REQ - 1) ? '0 : pickIdx + 1'b1;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_grant
    assign grantNext[g] = strb.takeReq && (int'(pickIdx) == g);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      grant   <= '0;
      refGo   <= 1'b0;
      offGo   <= 1'b0;
      memDown <= 1'b0;
    end else begin
      grant <= grantNext;
      refGo <= strb.takeRef;
      offGo <= strb.takeOff;
      if (strb.takeReq) ptr <= ptrNext;
      if (strb.takeOff)  memDown <= 1'b1;
      else if (cmdDone)  memDown <= 1'b0;
    end
  end

  // R10: grant is one-hot and the three strobes never overlap
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rstN) $onehot0(grant));
  a_r10_excl: assert property (@(posedge clk) disable iff (!rstN)
    $countones({|grant, refGo, offGo}) <= 1);
  // R3: a grant only goes to a requester that was valid at the decision
  a_r3_grant_valid: assert property (@(posedge clk) disable iff (!rstN)
    (|grant) |-> ((grant & $past(reqValid)) == grant));
  // R4: power-off only when nothing asked for the slot
  a_r4_off_idle: assert property (@(posedge clk) disable iff (!rstN)
    offGo |-> ($past(reqValid) == '0 && !$past(refReq)));
  // R6: refresh order only when refresh was pending
  a_r6_ref_src: assert property (@(posedge clk) disable iff (!rstN)
    refGo |-> $past(refReq));
  // R2: strobes are never back to back
  a_r2_gap: assert property (@(posedge clk) disable iff (!rstN)
    (|grant || refGo || offGo) |=> !(|grant || refGo || offGo));
  // R5: idle and refresh slots keep the pointer
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (refGo || offGo) |-> $stable(ptr));
  // R8: the power-down flag only rises with a power-off order
  a_r8_down_entry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDown) |-> offGo);
endmodule

// File: rtl/slot_pd_sched.sv
module slot_pd_sched
  import slot_pd_pkg::*;
#(
  parameter int NUM_REQ   = 4,
  parameter int SCHED_INT = 26,
  parameter int T_ENTER   = 4,
  parameter int T_EXIT    = 6,
  localparam int TW       = $clog2(SCHED_INT + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqValid,
  input  logic               refReq,
  input  logic               cmdDone,
  output logic [NUM_REQ-1:0] grant,
  output logic               refGo,
  output logic               offGo,
  output logic [TW-1:0]      offTime,
  output logic               memDown
);
  localparam int RESIDENCY = SCHED_INT - T_ENTER - T_EXIT;

  slotStrobeT strb;
  logic       anyReq;

  assign offTime = TW'(RESIDENCY);

  slot_pd_ctrl #(.SCHED_INT(SCHED_INT)) uCtrl (
    .clk(clk), .rstN(rstN), .anyReq(anyReq), .refReq(refReq),
    .cmdDone(cmdDone), .strb(strb)
  );

  slot_pd_dp #(.NUM_REQ(NUM_REQ)) uDp (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .refReq(refReq),
    .cmdDone(cmdDone), .strb(strb), .anyReq(anyReq), .grant(grant),
    .refGo(refGo), .offGo(offGo), .memDown(memDown)
  );
endmodule

// File: tb/sim_slot_pd_sched.sv
`timescale 1ns/1ps
module sim_slot_pd_sched;
  localparam int N = 4;
  localparam int SI = 26;
  localparam int TW = $clog2(SI + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] reqValid = '0;
  logic refReq = 1'b0;
  logic cmdDone = 1'b0;
  logic [N-1:0] grant;
  logic refGo, offGo, memDown;
  logic [TW-1:0] offTime;

  int checks = 0, errors = 0, cyc = 0;
  int gLat = 26, doneCnt = 0;
  int tPrev, tNow;

  // reference model state
  int mCnt = 0, mPtr = 0;
  bit mBusy = 0, mDown = 0, eRef = 0, eOff = 0;
  logic [N-1:0] eG = '0;

  slot_pd_sched u0 (.clk(clk), .rstN(rstN), .reqValid(reqValid), .refReq(refReq),
    .cmdDone(cmdDone), .grant(grant), .refGo(refGo), .offGo(offGo),
    .offTime(offTime), .memDown(memDown));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model, evaluated on the inputs present at the edge
  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mCnt = 0; mBusy = 0; mPtr = 0; mDown = 0; eG = '0; eRef = 0; eOff = 0;
    end else begin
      bit dec;
      eG = '0; eRef = 0; eOff = 0;
      dec = (mCnt == 0) && (!mBusy || cmdDone);
      if (dec) begin
        if (refReq) eRef = 1;
        else if (reqValid != 0) begin
          for (int k = 0; k < N; k++) begin
            int idx;
            idx = (mPtr + k) % N;
            if (eG == 0 && reqValid[idx]) begin
              eG[idx] = 1'b1;
              mPtr = (idx + 1) % N;
            end
          end
        end else eOff = 1;
        mCnt = SI - 1; mBusy = 1;
      end else begin
        if (mCnt > 0) mCnt--;
        if (cmdDone) mBusy = 0;
      end
      if (dec && eOff) mDown = 1;
      else if (cmdDone) mDown = 0;
    end
  end

  // per-cycle comparison and command-generator model
  always @(negedge clk) begin
    if (cyc > 0) begin
      chk(grant == eG, "R3 grant", int'(grant), int'(eG));
      chk(refGo == eRef, "R6 refGo", int'(refGo), int'(eRef));
      chk(offGo == eOff, "R4 offGo", int'(offGo), int'(eOff));
      chk(memDown == mDown, "R8 memDown", int'(memDown), int'(mDown));
    end
    cmdDone <= 1'b0;
    if (doneCnt > 0) begin
      doneCnt--;
      if (doneCnt == 0) cmdDone <= 1'b1;
    end
    if (offGo) doneCnt = SI - 1;
    else if (refGo) doneCnt = 44 - 1;
    else if (|grant) doneCnt = gLat - 1;
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic waitStrobe();
    do @(negedge clk); while (!(|grant || refGo || offGo));
    tPrev = tNow;
    tNow = cyc;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(grant == 0 && !refGo && !offGo && !memDown, "R1 reset outputs",
        int'({grant, refGo, offGo, memDown}), 0);
    reqValid = 4'b1111;
    rstN = 1'b1;
    waitStrobe();
    chk(grant == 4'b0001, "R1 first grant to requester 0", int'(grant), 1);
    for (int s = 1; s < 4; s++) begin
      waitStrobe();
      chk(grant == (4'b0001 << s), "R3 rotating grant", int'(grant), 1 << s);
      chk(tNow - tPrev == SI, "R2 slot spacing", tNow - tPrev, SI);
    end
    reqValid = '0;
    waitStrobe();
    chk(offGo == 1'b1, "R4 idle slot powers off", int'(offGo), 1);
    chk(offTime == TW'(16), "R4 residency value", int'(offTime), 16);
    @(negedge clk);
    chk(memDown == 1'b1, "R8 down during episode", int'(memDown), 1);
    repeat (9) @(negedge clk);
    reqValid = 4'b0100;
    waitStrobe();
    chk(grant == 4'b0100, "R9 late request granted", int'(grant), 4);
    chk(tNow - tPrev == SI, "R9 grant on unchanged boundary", tNow - tPrev, SI);
    chk(memDown == 1'b0, "R8 up by boundary", int'(memDown), 0);
    reqValid = '0;
    waitStrobe();
    chk(offGo == 1'b1, "R4 second idle slot", int'(offGo), 1);
    reqValid = 4'b1001;
    waitStrobe();
    chk(grant == 4'b1000, "R5 pointer held over idle slot", int'(grant), 8);
    reqValid = 4'b1111;
    refReq = 1'b1;
    waitStrobe();
    chk(refGo == 1'b1 && grant == 0, "R6 refresh takes slot", int'({refGo, grant}), 16);
    refReq = 1'b0;
    gLat = 37;
    waitStrobe();
    chk(tNow - tPrev == 44, "R7 refresh stretches slot", tNow - tPrev, 44);
    chk(grant == 4'b0001, "R5 pointer held over refresh", int'(grant), 1);
    reqValid = '0;
    waitStrobe();
    chk(tNow - tPrev == 37, "R7 long write stretches slot", tNow - tPrev, 37);
    chk(offGo == 1'b1 && grant == 0, "R10 single strobe", int'({grant, offGo}), 1);
    repeat (30) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule